// File: doc/BRIEF.md
# Serial Port Interrupt Combiner

This block gathers the eleven interrupt causes of a serial port into one raw status word and one enable mask, and drives six registered interrupt lines from their AND. One line is the combined request. The other five each carry one group: receive, transmit, receive timeout, modem status and line error.

Event pulses from the receive FIFO, the modem inputs and the line checker set raw bits. Software reaches the block over a small word-addressed register bus. Through it, software reads the raw and masked status, reads and writes the mask, and clears raw bits by writing ones to a separate clear register. A write to the transmit data register hands the byte to the transmitter and raises the transmit cause. The block does no serial shifting and no baud generation.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After a synchronous reset the raw status, the mask, all six lines and the transmit strobe are zero, and every register reads zero.
- R2: A one on `evt_set[i]` sets raw bit i at the next clock edge. The bit positions are: ring 0, CTS 1, DCD 2, DSR 3, receive 4, transmit 5, receive timeout 6, framing 7, parity 8, break 9, overrun 10. The raw status reads at word offset 2, in bits 10:0.
- R3: A write to word offset 0 sets raw bit 5. On the next cycle it also drives `tx_byte` with the low 8 bits of the write data, with `tx_byte_stb` high for exactly one cycle.
- R4: A write to word offset 4 clears each raw bit whose write-data bit is one. Raw bits written as zero keep their value.
- R5: When an event and a clear write hit the same raw bit in the same cycle, the bit ends up set.
- R6: The mask is written and read at word offset 1, in bits 10:0. Upper bits read as zero.
- R7: Word offset 3 reads raw status AND mask.
- R8: Writes to offsets 2 and 3 change neither the raw status nor the mask.
- R9: `irq_out[0]` is high exactly when some bit is set in both the raw status and the mask.
- R10: `irq_out[1]` to `irq_out[5]` carry the masked value of, in turn: the receive bit, the transmit bit, the timeout bit, the OR of bits 3:0, and the OR of bits 10:7.
- R11: The lines change at the same clock edge as the raw status or mask change that causes them, which is one cycle after the causing event or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_set | input | 11 | Per-cause set pulses |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| tx_byte | output | 8 | Byte handed to the transmitter |
| tx_byte_stb | output | 1 | One-cycle strobe for `tx_byte` |
| irq_out | output | 6 | Combined, receive, transmit, timeout, modem and error lines |

## Verification
Single-cause pulses under a full mask step the set pattern across all eleven positions. Each one shows whether the bit lands in the right raw position and on the right grouped line. Partial masks, such as alternating bits, show whether a line follows the masked value rather than the raw one.

Mixed traffic exposes an inverted or mis-indexed clear. A clear that removes only part of a fully set word is one such case. A clear that hits the same bit as a set pulse in the same cycle is another, and it separates set-wins priority from clear-wins priority.

Writes aimed at the read-only offsets show whether stray decoding occurs. A cycle-level reference model compares every line and the transmit strobe on every clock, which catches a result that appears one cycle late.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC  = 11;
    localparam int NLINE = 6;
    localparam int OFS_W = 3;

    localparam int B_RX   = 4;
    localparam int B_TX   = 5;
    localparam int B_TOUT = 6;

    localparam logic [NSRC-1:0] GRP_ALL   = 11'h7FF;
    localparam logic [NSRC-1:0] GRP_RX    = 11'h010;
    localparam logic [NSRC-1:0] GRP_TX    = 11'h020;
    localparam logic [NSRC-1:0] GRP_TOUT  = 11'h040;
    localparam logic [NSRC-1:0] GRP_MODEM = 11'h00F;
    localparam logic [NSRC-1:0] GRP_ERR   = 11'h780;

    // Index 0 = combined line, then rx, tx, timeout, modem, error
    localparam logic [NLINE-1:0][NSRC-1:0] LINE_GROUPS =
        {GRP_ERR, GRP_MODEM, GRP_TOUT, GRP_TX, GRP_RX, GRP_ALL};

    typedef enum logic [OFS_W-1:0] {
        OFS_TXDATA = 3'd0,
        OFS_MASK   = 3'd1,
        OFS_RAW    = 3'd2,
        OFS_MASKED = 3'd3,
        OFS_CLEAR  = 3'd4
    } reg_ofs_e;

    typedef struct packed {
        logic            tx_wr;
        logic            mask_wr;
        logic            clr_wr;
        logic [NSRC-1:0] bits;
    } bus_cmd_t;

    function automatic logic group_hit(logic [NSRC-1:0] masked,
                                       logic [NSRC-1:0] grp);
        return |(masked & grp);
    endfunction

endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NSRC-1:0]   raw_q,
    input  logic [NSRC-1:0]   mask_q,
    output bus_cmd_t          cmd,
    output logic [DATA_W-1:0] bus_rdata
);
    logic wr_en;
    assign wr_en = bus_sel && bus_wr;

    always_comb begin
        cmd.tx_wr   = wr_en && (bus_addr == ADDR_W'(OFS_TXDATA));
        cmd.mask_wr = wr_en && (bus_addr == ADDR_W'(OFS_MASK));
        cmd.clr_wr  = wr_en && (bus_addr == ADDR_W'(OFS_CLEAR));
        cmd.bits    = bus_wdata[NSRC-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                ADDR_W'(OFS_MASK):   bus_rdata = DATA_W'(mask_q);
                ADDR_W'(OFS_RAW):    bus_rdata = DATA_W'(raw_q);
                ADDR_W'(OFS_MASKED): bus_rdata = DATA_W'(raw_q & mask_q);
                default:             bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt_set,
    input  bus_cmd_t        cmd,
    output logic [NSRC-1:0] raw_q,
    output logic [NSRC-1:0] mask_q,
    output logic [NSRC-1:0] raw_d,
    output logic [NSRC-1:0] mask_d
);
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;

    always_comb begin
        set_vec = evt_set;
        if (cmd.tx_wr) set_vec[B_TX] = 1'b1;
        clr_vec = cmd.clr_wr ? cmd.bits : '0;
        raw_d   = (raw_q & ~clr_vec) | set_vec;
        mask_d  = cmd.mask_wr ? cmd.bits : mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q  <= raw_d;
            mask_q <= mask_d;
        end
    end

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        (|evt_set) |=> ((raw_q & $past(evt_set)) == $past(evt_set)));   // R2
    AST_TX_SETS: assert property (@(posedge clk) disable iff (rst)
        cmd.tx_wr |=> raw_q[B_TX]);                                      // R3
    AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (rst)
        cmd.clr_wr |=> ((raw_q & $past(cmd.bits & ~evt_set
                         & ~(cmd.tx_wr ? GRP_TX : '0))) == '0));         // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr_wr && |(cmd.bits & evt_set))
        |=> ((raw_q & $past(cmd.bits & evt_set)) != '0));               // R5
    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
        cmd.mask_wr |=> (mask_q == $past(cmd.bits)));                   // R6
    AST_RAW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cmd.clr_wr && !cmd.tx_wr && evt_set == '0) |=> $stable(raw_q)); // R8
endmodule

// File: rtl/uart_irq_lines.sv
module uart_irq_lines
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  raw_d,
    input  logic [NSRC-1:0]  mask_d,
    output logic [NLINE-1:0] irq_q
);
    logic [NSRC-1:0]  masked_d;
    logic [NLINE-1:0] line_d;

    assign masked_d = raw_d & mask_d;

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        assign line_d[g] = group_hit(masked_d, LINE_GROUPS[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= line_d;
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   evt_set,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_byte_stb,
    output logic [NLINE-1:0]  irq_out
);
    bus_cmd_t        cmd;
    logic [NSRC-1:0] raw_q, mask_q, raw_d, mask_d;

    uart_irq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .raw_q(raw_q), .mask_q(mask_q),
        .cmd(cmd), .bus_rdata(bus_rdata)
    );

    uart_irq_status u_status (
        .clk(clk), .rst(rst), .evt_set(evt_set), .cmd(cmd),
        .raw_q(raw_q), .mask_q(mask_q), .raw_d(raw_d), .mask_d(mask_d)
    );

    uart_irq_lines u_lines (
        .clk(clk), .rst(rst), .raw_d(raw_d), .mask_d(mask_d), .irq_q(irq_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_byte     <= '0;
            tx_byte_stb <= 1'b0;
        end else begin
            tx_byte_stb <= cmd.tx_wr;
            if (cmd.tx_wr) tx_byte <= bus_wdata[BYTE_W-1:0];
        end
    end

    AST_COMBINED_LINE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out[0] == |(raw_q & mask_q)));                    // R9
    AST_ERR_LINE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out[5] == |(raw_q & mask_q & GRP_ERR)));          // R10
    AST_STB_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_byte_stb |-> $past(cmd.tx_wr));                              // R3
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] evt_set = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  tx_byte;
    logic        tx_byte_stb;
    logic [5:0]  irq_out;

    int checks = 0, errors = 0;
    int m_raw = 0, m_mask = 0, m_stb = 0, m_byte = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_irq_ctrl i_uart_irq_ctrl (
        .clk(clk), .rst(rst), .evt_set(evt_set), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tx_byte(tx_byte), .tx_byte_stb(tx_byte_stb),
        .irq_out(irq_out)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_lines();
        int m = m_raw & m_mask;
        int l = 0;
        if (m != 0)          l |= 1;
        if (m & 'h010)       l |= 2;
        if (m & 'h020)       l |= 4;
        if (m & 'h040)       l |= 8;
        if (m & 'h00F)       l |= 16;
        if (m & 'h780)       l |= 32;
        return l;
    endfunction

    // One clock: drive at negedge, step model, compare at next negedge (R9 R10 R11)
    task automatic cycle(int evt, bit wr, int addr, int wdata);
        int nraw;
        evt_set = 11'(evt); bus_sel = wr; bus_wr = wr;
        bus_addr = 3'(addr); bus_wdata = 16'(wdata);
        nraw = m_raw;
        if (wr && addr == 4) nraw &= ~(wdata & 'h7FF);
        nraw |= evt;
        if (wr && addr == 0) nraw |= 'h020;
        if (wr && addr == 1) m_mask = wdata & 'h7FF;
        m_stb = (wr && addr == 0);
        if (m_stb) m_byte = wdata & 'hFF;
        m_raw = nraw;
        @(negedge clk);
        evt_set = '0; bus_sel = 0; bus_wr = 0;
        check("R9/R10/R11 lines", int'(irq_out), model_lines());
        check("R3 strobe", int'(tx_byte_stb), m_stb);
        if (m_stb) check("R3 byte", int'(tx_byte), m_byte);
    endtask

    task automatic rd(string req, int addr, int exp);
        bus_sel = 1; bus_wr = 0; bus_addr = 3'(addr);
        #1;
        check(req, int'(bus_rdata), exp);
        bus_sel = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 lines", int'(irq_out), 0);
        check("R1 strobe", int'(tx_byte_stb), 0);
        for (int a = 0; a < 8; a++) rd("R1 read", a, 0);
        // R2 each position, with mask off then full mask
        for (int b = 0; b < 11; b++) begin
            cycle(1 << b, 0, 0, 0);
            rd("R2 raw position", 2, 1 << b);
            cycle(0, 1, 4, 1 << b);
        end
        cycle(0, 1, 1, 'hFFFF);
        rd("R6 mask upper bits zero", 1, 'h7FF);
        for (int b = 0; b < 11; b++) begin
            cycle(1 << b, 0, 0, 0);
            rd("R7 masked single", 3, 1 << b);
            cycle(0, 1, 4, 1 << b);
        end
        // R4 partial clear
        cycle('h7FF, 0, 0, 0);
        cycle(0, 1, 4, 'h0F0);
        rd("R4 partial clear", 2, 'h70F);
        // R5 set wins
        cycle('h080, 1, 4, 'h7FF);
        rd("R5 set wins", 2, 'h080);
        // R6/R7 partial mask
        cycle('h7FF, 1, 1, 'h0A5);
        rd("R6 mask readback", 1, 'h0A5);
        rd("R7 masked status", 3, 'h0A5);
        cycle(0, 1, 4, 'h7FF);
        cycle('h050, 0, 0, 0);
        rd("R7 masked sparse", 3, 'h000);
        // R8 writes to read-only offsets
        cycle(0, 1, 2, 'h7FF);
        cycle(0, 1, 3, 'h000);
        rd("R8 raw unchanged", 2, 'h050);
        rd("R8 mask unchanged", 1, 'h0A5);
        // R3 transmit write
        cycle(0, 1, 1, 'h020);
        cycle(0, 1, 0, 'h3C5);
        rd("R3 tx raw bit", 2, 'h070);
        cycle(0, 1, 4, 'h020);
        cycle(0, 1, 0, 'h07E);
        cycle(0, 0, 0, 0);
        // R10 group lines under varied masks
        cycle(0, 1, 4, 'h7FF);
        cycle('h208, 1, 1, 'h7C8);
        cycle('h040, 1, 1, 'h040);
        cycle(0, 1, 4, 'h7FF);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule